// File: doc/BRIEF.md
# PHY Reset Sequencer

This block produces the hardware reset pulse for an external Ethernet PHY when a host asks for one. A one-cycle start request launches the sequence. If the management word reports that PHY resets are currently forbidden, the sequencer finishes at once, drives no reset and reports success. Otherwise it sets the reset bit of the device control word for a programmable number of microseconds and then returns the word to the value it would otherwise have. It then waits a fixed settling time and polls a reset-complete flag in a power-management status word once per microsecond. The number of polls is limited. If the limit is reached, a timeout flag is raised, and the sequence still finishes normally.

Every delay is counted in microseconds. An internal divider derives a one-microsecond tick from the clock frequency. The divider restarts at every phase change, so each phase lasts an exact number of clock periods. The host sees a busy level while the sequence runs, a one-cycle done pulse at the end, and a timeout level that stays valid until the next accepted start.

Top module: `phy_rst_seq`

## Requirements
- R1: If bit 18 of `mgmt_ctrl_i` is 1 on the accepted start cycle, `done_o` pulses on the next cycle. No reset is driven and `timeout_o` is 0.
- R2: When the start is accepted with bit 18 at 0, `phy_rst_o` rises on the cycle after start. It stays high for exactly H×CLK_MHZ cycles, where H is the hold time in microseconds.
- R3: While `phy_rst_o` is high, `ctrl_word_o` equals `ctrl_word_i` with bit 31 set and all other bits unchanged. At all other times it equals `ctrl_word_i`.
- R4: A hold input of zero is treated as one microsecond.
- R5: After release, the sequencer waits SETTLE_US×CLK_MHZ cycles. It then samples bit 8 of `pm_status_i` once at the end of each CLK_MHZ-cycle period.
- R6: The first poll that sees bit 8 set ends the sequence. `done_o` pulses on the next cycle, with `timeout_o` at 0.
- R7: If POLL_MAX polls all see bit 8 clear, `timeout_o` rises together with `done_o`. It then holds until the next accepted start, which clears it one cycle later.
- R8: `busy_o` is high from the cycle after an accepted start through the done cycle. A start request while busy is ignored.
- R9: `done_o` is high for exactly one cycle per accepted start.
- R10: Bits of `mgmt_ctrl_i` other than bit 18 have no effect on whether a reset is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| mgmt_ctrl_i | input | 32 | Management control word; bit 18 forbids the reset |
| hold_us_i | input | HOLD_W | Reset hold time in microseconds |
| ctrl_word_i | input | 32 | Device control word from the host |
| ctrl_word_o | output | 32 | Device control word to the PHY side, bit 31 = reset |
| pm_status_i | input | 32 | Power-management status word; bit 8 = reset complete |
| phy_rst_o | output | 1 | Reset line level (same as bit 31 forced) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| timeout_o | output | 1 | Poll budget exhausted in the last sequence |

## Verification
Let D be CLK_MHZ and let the start be sampled on edge 1. The done pulse is due after edge 1 for a blocked start. For any other start it is due after edge 1+(H+SETTLE_US+k)·D, where k is the index of the first poll that sees the completion bit, capped at POLL_MAX. The bench drives the completion bit after a chosen edge and computes k from that edge. It then samples every output half a cycle after each edge, so a pulse arriving one cycle early or late is reported. The bench also counts reset-high cycles against H·D and compares the control word against the input in every cycle.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HOLD,
      SQ_SETTLE,
      SQ_POLL,
      SQ_FIN
   } seq_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/phy_us_tick.sv
module phy_us_tick #(
   parameter int unsigned CLK_MHZ = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   localparam int unsigned CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_MHZ - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr_i)    cnt_q <= '0;
      else if (tick_o)   cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (CLK_MHZ < 1) begin : g_bad_div
         $error("CLK_MHZ must be at least 1");
      end
      if (CLK_MHZ > 1) begin : g_gap_chk
         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && !clr_i) |=> !tick_o); // R5
      end
   endgenerate
endmodule

// File: rtl/phy_us_timer.sv
module phy_us_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   output logic         last_o
);
   logic [W-1:0] rem_q;

   assign last_o = tick_i && (rem_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rem_q <= '0;
      else if (load_i)                  rem_q <= load_val_i;
      else if (tick_i && rem_q != '0)   rem_q <= rem_q - 1'b1;
   end

   generate
      if (W < 1) begin : g_bad_w
         $error("timer width must be at least 1");
      end
   endgenerate

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (load_val_i != '0)); // R4
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
   import phy_rst_pkg::*;
#(
   parameter int unsigned CLK_MHZ   = 50,
   parameter int unsigned HOLD_W    = 16,
   parameter int unsigned SETTLE_US = 150,
   parameter int unsigned POLL_MAX  = 10000,
   parameter int unsigned BLK_BIT   = 18,
   parameter int unsigned RST_BIT   = 31,
   parameter int unsigned CMPL_BIT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       mgmt_ctrl_i,
   input  logic [HOLD_W-1:0] hold_us_i,
   input  logic [31:0]       ctrl_word_i,
   output logic [31:0]       ctrl_word_o,
   input  logic [31:0]       pm_status_i,
   output logic              phy_rst_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o
);
   localparam int unsigned SET_W = $clog2(SETTLE_US + 1);
   localparam int unsigned PH_W  = max2(HOLD_W, SET_W);
   localparam int unsigned PL_W  = $clog2(POLL_MAX + 1);
   localparam logic [31:0] RST_MASK = 32'(1) << RST_BIT;

   generate
      if (BLK_BIT >= WORD_W || RST_BIT >= WORD_W || CMPL_BIT >= WORD_W) begin : g_bad_bit
         $error("bit positions must lie inside the 32-bit words");
      end
      if (SETTLE_US < 1 || POLL_MAX < 1 || HOLD_W < 1) begin : g_bad_cnt
         $error("SETTLE_US, POLL_MAX and HOLD_W must be at least 1");
      end
   endgenerate

   seq_state_t state_q, state_d;
   logic       tick, tick_clr;
   logic       accept, blocked, cmpl;
   logic       ph_load, ph_tick, ph_last;
   logic       pl_load, pl_tick, pl_last;
   logic [PH_W-1:0] ph_val, hold_eff;
   logic       to_set, to_q;

   assign accept   = (state_q == SQ_IDLE) && start_i;
   assign blocked  = mgmt_ctrl_i[BLK_BIT];
   assign cmpl     = pm_status_i[CMPL_BIT];
   assign hold_eff = (hold_us_i == '0) ? PH_W'(1) : PH_W'(hold_us_i);

   always_comb begin
      state_d = state_q;
      ph_load = 1'b0;
      ph_val  = hold_eff;
      pl_load = 1'b0;
      to_set  = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (accept) begin
               if (blocked) begin
                  state_d = SQ_FIN;
               end else begin
                  state_d = SQ_HOLD;
                  ph_load = 1'b1;
               end
            end
         end
         SQ_HOLD: begin
            if (ph_last) begin
               state_d = SQ_SETTLE;
               ph_load = 1'b1;
               ph_val  = PH_W'(SETTLE_US);
            end
         end
         SQ_SETTLE: begin
            if (ph_last) begin
               state_d = SQ_POLL;
               pl_load = 1'b1;
            end
         end
         SQ_POLL: begin
            if (tick) begin
               if (cmpl) begin
                  state_d = SQ_FIN;
               end else if (pl_last) begin
                  state_d = SQ_FIN;
                  to_set  = 1'b1;
               end
            end
         end
         SQ_FIN:  state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   assign tick_clr = (state_d != state_q);
   assign ph_tick  = tick && ((state_q == SQ_HOLD) || (state_q == SQ_SETTLE));
   assign pl_tick  = tick && (state_q == SQ_POLL) && !cmpl;

   phy_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr_i(tick_clr), .tick_o(tick)
   );

   phy_us_timer #(.W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .load_i(ph_load), .load_val_i(ph_val),
      .tick_i(ph_tick), .last_o(ph_last)
   );

   phy_us_timer #(.W(PL_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .load_i(pl_load), .load_val_i(PL_W'(POLL_MAX)),
      .tick_i(pl_tick), .last_o(pl_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         to_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept)      to_q <= 1'b0;
         else if (to_set) to_q <= 1'b1;
      end
   end

   assign phy_rst_o   = (state_q == SQ_HOLD);
   assign ctrl_word_o = phy_rst_o ? (ctrl_word_i | RST_MASK) : ctrl_word_i;
   assign busy_o      = (state_q != SQ_IDLE);
   assign done_o      = (state_q == SQ_FIN);
   assign timeout_o   = to_q;

   AST_BLOCK_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && blocked) |=> (done_o && !phy_rst_o)); // R1
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_RST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rst_o |-> busy_o); // R8
   AST_TO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(timeout_o)); // R7
   AST_START_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !blocked) |=> (phy_rst_o && !done_o)); // R2
endmodule

// File: tb/tb_phy_rst_seq.sv
module tb_phy_rst_seq;
   localparam int D  = 4;
   localparam int S  = 5;
   localparam int PM = 20;
   localparam int HW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [31:0] mgmt_ctrl_i = '0;
   logic [HW-1:0] hold_us_i = '0;
   logic [31:0] ctrl_word_i = '0;
   logic [31:0] ctrl_word_o;
   logic [31:0] pm_status_i = '0;
   logic phy_rst_o, busy_o, done_o, timeout_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   phy_rst_seq #(.CLK_MHZ(D), .HOLD_W(HW), .SETTLE_US(S), .POLL_MAX(PM)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mgmt_ctrl_i(mgmt_ctrl_i),
      .hold_us_i(hold_us_i), .ctrl_word_i(ctrl_word_i), .ctrl_word_o(ctrl_word_o),
      .pm_status_i(pm_status_i), .phy_rst_o(phy_rst_o), .busy_o(busy_o),
      .done_o(done_o), .timeout_o(timeout_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // e <= 0: completion bit high before start; else raised after edge e
   task automatic run(input int hold, input logic [31:0] ctl, input logic [31:0] mg,
                      input int e, input bit stray);
      int h, n, k, p, rst_cnt, ctl_err, done_cnt, done_at, busy_err;
      bit blk, exp_to;
      blk = mg[18];
      h = (hold == 0) ? 1 : hold;
      p = 1 + (h + S) * D;
      k = 1;
      while (k <= PM && !(e <= 0 || p + k * D >= e + 1)) k++;
      exp_to = !blk && (k > PM);
      if (k > PM) k = PM;
      n = blk ? 1 : 1 + (h + S + k) * D;
      rst_cnt = 0; ctl_err = 0; done_cnt = 0; done_at = -1; busy_err = 0;
      pm_status_i = (e <= 0) ? 32'h0000_0100 : 32'h0000_feff;
      hold_us_i = HW'(hold);
      ctrl_word_i = ctl;
      mgmt_ctrl_i = mg;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(timeout_o == 1'b0, "R7 cleared after start", timeout_o, 0);
      for (int i = 1; i <= n + 2; i++) begin
         if (phy_rst_o) rst_cnt++;
         if (ctrl_word_o != (phy_rst_o ? (ctl | 32'h8000_0000) : ctl)) ctl_err++;
         if (done_o) begin done_cnt++; if (done_at < 0) done_at = i; end
         if (busy_o != (i <= n)) busy_err++;
         if (phy_rst_o != (!blk && i <= h * D)) ctl_err++;
         if (i == e) pm_status_i = 32'h0000_0100;
         if (stray && i == 3) start_i = 1'b1;
         if (stray && i == 4) start_i = 1'b0;
         @(negedge clk);
      end
      chk(rst_cnt == (blk ? 0 : h * D), blk ? "R1/R10 no reset" : "R2/R4 hold length", rst_cnt, blk ? 0 : h * D);
      chk(ctl_err == 0, "R3 control word", ctl_err, 0);
      chk(done_at == n, blk ? "R1 done time" : "R5/R6 done time", done_at, n);
      chk(done_cnt == 1, "R9 single done", done_cnt, 1);
      chk(busy_err == 0, "R8 busy window", busy_err, 0);
      chk(timeout_o == exp_to, "R7 timeout", timeout_o, exp_to);
      repeat (5) @(negedge clk);
      chk(timeout_o == exp_to && !done_o, "R7 timeout held", timeout_o, exp_to);
      pm_status_i = '0;
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!phy_rst_o && !busy_o && !done_o && !timeout_o, "R8 reset state",
          {phy_rst_o, busy_o, done_o, timeout_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 blocked starts, R10 other management bits ignored
      run(3, 32'h1234_5678, 32'h0004_0000, 0, 1'b0);
      run(2, 32'h0000_0000, 32'hffff_ffff, 1000, 1'b0);
      for (int hold = 0; hold <= 4; hold++) begin
         run(hold, 32'h0a5a_0001 + hold, 32'hfffb_ffff, 0, 1'b0);    // R10, R6
         run(hold, 32'h8000_00ff, 32'h0000_0000, 30 + 7 * hold, 1'b0); // R5, R3
         run(hold, 32'h0f0f_0f0f, 32'h0000_0000, 1000, 1'b0);         // R7
         run(hold, 32'h0000_1000, 32'h0000_0000, 61, 1'b1);           // R8 stray start
      end
      run(4, 32'hdead_beef, 32'h0004_0000, 1000, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule